// File: doc/BRIEF.md
# Programmable Card-Cycle Strobe Timer

This block times a single access cycle on a legacy PC Card style bus. Each cycle has three phases: address setup, command strobe and recovery. A start request is accepted while the block is idle. The block then drives an address-valid/busy indication for the whole cycle and raises the command strobe only during the command phase. It issues a one-clock done pulse once recovery has finished.

Each phase lasts a whole number of internal ticks. The tick counts come from three 8-bit timing registers in one of two timer sets. Software loads these registers through a simple write port that takes an index, data and a strobe. The internal tick is normally the bus clock itself. A source bit selects a slower prescaled tick instead, and a divide bit halves whichever tick is selected.

When a cycle is accepted, the block copies the timing values, the timer-set choice and the tick configuration. A cycle that is already running therefore cannot be disturbed by register writes or by changes on the select inputs. A start that arrives during recovery is remembered and begins as soon as recovery ends. Consecutive cycles therefore always keep the full recovery gap.

Top module: `card_strobe_timer`

## Requirements
- R1: While reset is held, and on the first clock after it is released, busy, cmd_strobe and done are all low.
- R2: The setup phase lasts (setup value + 1) ticks. During setup, busy is high and cmd_strobe is low.
- R3: cmd_strobe is high for exactly (command value + 1) ticks without a gap, and only while busy is high.
- R4: Recovery lasts (recovery value + 2) ticks, with busy high and cmd_strobe low. done is then high for exactly one clock, the first clock in which busy is low.
- R5: Timer set 0 uses indices 3Ah, 3Bh and 3Ch for setup, command and recovery, and resets to 00h, 07h and 04h, which give 1, 8 and 6 ticks. Timer set 1 uses 3Dh, 3Eh and 3Fh and resets to 00h in all three fields. A write to any other index changes nothing.
- R6: With clk_src_sel=0 and clk_div_en=0, one tick is one clock. clk_div_en=1 doubles the tick length. clk_src_sel=1 selects a tick of ALT_DIV clocks (3 by default), so both bits set give 6 clocks per tick.
- R7: set_sel, clk_src_sel and clk_div_en are sampled only when a start is accepted. Changing them mid-cycle does not alter the running cycle.
- R8: A register write made during a cycle does not change that cycle. It takes effect from the next accepted cycle.
- R9: start_req is accepted from idle, and busy rises on the next clock. A start raised during setup or command is ignored. A start raised during recovery is held, and the new cycle begins on the clock after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to begin an access cycle |
| set_sel | input | 1 | Timer set used by the next accepted cycle |
| wr_en | input | 1 | Timing register write strobe |
| wr_idx | input | 8 | Timing register index |
| wr_data | input | 8 | Timing register write data |
| clk_src_sel | input | 1 | 0: bus clock ticks, 1: prescaled ALT_DIV tick |
| clk_div_en | input | 1 | 1: halve the selected tick rate |
| cmd_strobe | output | 1 | Command strobe, high in the command phase |
| busy | output | 1 | Address valid / cycle in progress |
| done | output | 1 | One-clock pulse after recovery ends |

## Verification
The timing is exercised with several patterns:
- the reset values of both timer sets;
- a table of programmed setup, command and recovery values, including all-zero fields, across all four tick settings;
- writes to indices just outside the two timer sets.

The table separates an off-by-one in any single phase from an error in the tick length, because each entry changes the phase counts and the clocks per tick independently. Directed runs change the registers and the select inputs partway through a cycle, which shows whether a running cycle is isolated from them. Starts raised during the command phase and during recovery show whether the block drops or holds a request, depending on the phase in which it arrives.

// File: rtl/cst_pkg.sv
package cst_pkg;

    localparam int CST_REG_W = 8;

    typedef logic [CST_REG_W-1:0] treg_t;
    typedef logic [CST_REG_W:0]   tcnt_t;

    typedef struct packed {
        treg_t setup;
        treg_t command;
        treg_t recov;
    } timing_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_CMD   = 2'd2,
        PH_RECOV = 2'd3
    } phase_e;

    typedef struct packed {
        timing_t tm;
        logic    slow_src;
        logic    half_rate;
    } cycle_cfg_t;

    // field order inside one timer set: setup, command, recovery
    localparam int FLD_SETUP   = 0;
    localparam int FLD_COMMAND = 1;
    localparam int FLD_RECOV   = 2;
    localparam int FLDS_PER_SET = 3;

    localparam treg_t SET0_SETUP_RST   = 8'h00;
    localparam treg_t SET0_COMMAND_RST = 8'h07;
    localparam treg_t SET0_RECOV_RST   = 8'h04;

    function automatic timing_t reset_timing(input int set_num);
        timing_t t;
        if (set_num == 0) begin
            t.setup   = SET0_SETUP_RST;
            t.command = SET0_COMMAND_RST;
            t.recov   = SET0_RECOV_RST;
        end else begin
            t = '0;
        end
        return t;
    endfunction

    // tick index (from 0) on which the given phase ends
    function automatic tcnt_t phase_last(input phase_e ph, input timing_t t);
        tcnt_t v;
        case (ph)
            PH_SETUP: v = {1'b0, t.setup};
            PH_CMD:   v = {1'b0, t.command};
            PH_RECOV: v = {1'b0, t.recov} + tcnt_t'(1);
            default:  v = '0;
        endcase
        return v;
    endfunction

    function automatic phase_e phase_next(input phase_e ph);
        phase_e n;
        case (ph)
            PH_SETUP: n = PH_CMD;
            PH_CMD:   n = PH_RECOV;
            default:  n = PH_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cst_regfile.sv
module cst_regfile
    import cst_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int IDX_W    = 8,
    parameter int IDX_BASE = 58
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  treg_t            wr_data,
    output timing_t          sets_o [NUM_SETS]
);

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
        localparam int SET_BASE = IDX_BASE + k * FLDS_PER_SET;
        localparam logic [IDX_W-1:0] IDX_S = IDX_W'(SET_BASE + FLD_SETUP);
        localparam logic [IDX_W-1:0] IDX_C = IDX_W'(SET_BASE + FLD_COMMAND);
        localparam logic [IDX_W-1:0] IDX_R = IDX_W'(SET_BASE + FLD_RECOV);

        timing_t set_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                set_q <= reset_timing(k);
            end else if (wr_en) begin
                if (wr_idx == IDX_S) set_q.setup   <= wr_data;
                if (wr_idx == IDX_C) set_q.command <= wr_data;
                if (wr_idx == IDX_R) set_q.recov   <= wr_data;
            end
        end

        assign sets_o[k] = set_q;
    end

endmodule

// File: rtl/cst_tick_gen.sv
module cst_tick_gen #(
    parameter int ALT_DIV = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic slow_src,
    input  logic half_rate,
    output logic tick
);

    localparam int MAX_PERIOD = 2 * ALT_DIV;
    localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;

    always_comb begin
        case ({slow_src, half_rate})
            2'b00:   last_val = '0;
            2'b01:   last_val = CNT_W'(1);
            2'b10:   last_val = CNT_W'(ALT_DIV - 1);
            default: last_val = CNT_W'(MAX_PERIOD - 1);
        endcase
    end

    assign tick = run && (cnt_q == last_val);

    // prescaler restarts with every cycle so each phase is a whole tick count
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/cst_phase_fsm.sv
module cst_phase_fsm
    import cst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  timing_t    sel_timing,
    input  logic       slow_src_in,
    input  logic       half_rate_in,
    input  logic       tick,
    output phase_e     phase_o,
    output cycle_cfg_t cfg_o,
    output logic       done_o
);

    phase_e     phase_q;
    tcnt_t      cnt_q;
    logic       pend_q;
    cycle_cfg_t cfg_q;
    logic       done_q;

    logic accept;
    logic last_hit;

    assign accept   = (phase_q == PH_IDLE) && (start_req || pend_q);
    assign last_hit = tick && (cnt_q == phase_last(phase_q, cfg_q.tm));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            cfg_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_RECOV) && last_hit;

            if (accept) begin
                cfg_q.tm        <= sel_timing;
                cfg_q.slow_src  <= slow_src_in;
                cfg_q.half_rate <= half_rate_in;
                phase_q         <= PH_SETUP;
                cnt_q           <= '0;
                pend_q          <= 1'b0;
            end else if (phase_q != PH_IDLE && tick) begin
                if (last_hit) begin
                    cnt_q   <= '0;
                    phase_q <= phase_next(phase_q);
                end else begin
                    cnt_q <= cnt_q + tcnt_t'(1);
                end
            end

            if (phase_q == PH_RECOV && start_req) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign phase_o = phase_q;
    assign cfg_o   = cfg_q;
    assign done_o  = done_q;

endmodule

// File: rtl/card_strobe_timer.sv
module card_strobe_timer
    import cst_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int ALT_DIV  = 3,
    parameter int IDX_W    = 8,
    parameter int IDX_BASE = 58,
    localparam int SEL_W   = $clog2(NUM_SETS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_req,
    input  logic [SEL_W-1:0]     set_sel,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [CST_REG_W-1:0] wr_data,
    input  logic                 clk_src_sel,
    input  logic                 clk_div_en,
    output logic                 cmd_strobe,
    output logic                 busy,
    output logic                 done
);

    timing_t    sets [NUM_SETS];
    timing_t    sel_timing;
    phase_e     phase;
    cycle_cfg_t cfg;
    logic       tick;

    cst_regfile #(
        .NUM_SETS (NUM_SETS),
        .IDX_W    (IDX_W),
        .IDX_BASE (IDX_BASE)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .sets_o  (sets)
    );

    assign sel_timing = sets[set_sel];

    cst_tick_gen #(
        .ALT_DIV (ALT_DIV)
    ) u_tick (
        .clk       (clk),
        .rst       (rst),
        .run       (phase != PH_IDLE),
        .slow_src  (cfg.slow_src),
        .half_rate (cfg.half_rate),
        .tick      (tick)
    );

    cst_phase_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_req    (start_req),
        .sel_timing   (sel_timing),
        .slow_src_in  (clk_src_sel),
        .half_rate_in (clk_div_en),
        .tick         (tick),
        .phase_o      (phase),
        .cfg_o        (cfg),
        .done_o       (done)
    );

    assign busy       = (phase != PH_IDLE);
    assign cmd_strobe = (phase == PH_CMD);

endmodule

// File: rtl/cst_checker.sv
module cst_checker (
    input logic clk,
    input logic rst,
    input logic start_req,
    input logic busy,
    input logic cmd_strobe,
    input logic done
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy && !cmd_strobe && !done));

    // R3
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |-> busy);

    // R2
    setup_before_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_strobe) |-> $past(busy));

    // R4
    recov_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_strobe) |-> busy);

    // R4
    done_on_busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    idle_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_req) |=> busy);

endmodule

bind card_strobe_timer cst_checker u_cst_checker (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .busy       (busy),
    .cmd_strobe (cmd_strobe),
    .done       (done)
);

// File: tb/card_strobe_timer_bench.sv
module card_strobe_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ALT        = 3;
    localparam int BASE_IDX   = 58;
    localparam int NVEC       = 6;

    // {sel, src, div, setup, command, recovery}
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 8'd2, 8'd3, 8'd1},
        {1'b1, 1'b0, 1'b1, 8'd0, 8'd2, 8'd0},
        {1'b0, 1'b1, 1'b0, 8'd1, 8'd1, 8'd1},
        {1'b1, 1'b1, 1'b1, 8'd0, 8'd0, 8'd0},
        {1'b0, 1'b0, 1'b1, 8'd4, 8'd0, 8'd3},
        {1'b1, 1'b0, 1'b0, 8'd5, 8'd9, 8'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic [0:0] set_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_idx = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       clk_src_sel = 1'b0;
    logic       clk_div_en = 1'b0;
    logic       cmd_strobe;
    logic       busy;
    logic       done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    card_strobe_timer #(.ALT_DIV(ALT)) u_card_strobe_timer (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .set_sel     (set_sel),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .clk_src_sel (clk_src_sel),
        .clk_div_en  (clk_div_en),
        .cmd_strobe  (cmd_strobe),
        .busy        (busy),
        .done        (done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_raw(input int idx, input int val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_idx  = 8'(idx);
        wr_data = 8'(val);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic program_set(input int set, input int s, input int c, input int r);
        wr_raw(BASE_IDX + 3 * set + 0, s);
        wr_raw(BASE_IDX + 3 * set + 1, c);
        wr_raw(BASE_IDX + 3 * set + 2, r);
    endtask

    task automatic launch(input int sel, input int src, input int div);
        @(negedge clk);
        set_sel     = 1'(sel);
        clk_src_sel = src[0];
        clk_div_en  = div[0];
        start_req   = 1'b1;
        @(negedge clk);
        start_req   = 1'b0;
    endtask

    // samples at each falling edge from the current one until done
    task automatic measure(output int su, output int cm, output int rc);
        bit seen_cmd = 1'b0;
        bit got_done = 1'b0;
        su = 0; cm = 0; rc = 0;
        for (int i = 0; i < 4000 && !got_done; i++) begin
            if (cmd_strobe) begin
                cm++;
                seen_cmd = 1'b1;
            end else if (busy) begin
                if (seen_cmd) rc++;
                else su++;
            end
            if (done) begin
                got_done = 1'b1;
                chk("R4 busy low with done", int'(busy), 0);
            end else begin
                @(negedge clk);
            end
        end
        chk("R4 done reached", int'(got_done), 1);
    endtask

    task automatic expect_cycle(input string tag, input int su, input int cm, input int rc,
                                input int esu, input int ecm, input int erc);
        chk({tag, " R2 setup clocks"}, su, esu);
        chk({tag, " R3 command clocks"}, cm, ecm);
        chk({tag, " R4 recovery clocks"}, rc, erc);
    endtask

    task automatic full_cycle(input string tag, input int sel, input int src, input int div,
                              input int esu, input int ecm, input int erc);
        int su, cm, rc;
        launch(sel, src, div);
        measure(su, cm, rc);
        @(negedge clk);
        chk({tag, " R4 done one clock"}, int'(done), 0);
        expect_cycle(tag, su, cm, rc, esu, ecm, erc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int su, cm, rc;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 strobe in reset", int'(cmd_strobe), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 strobe after reset", int'(cmd_strobe), 0);
        chk("R1 done after reset", int'(done), 0);

        // R5 reset contents and index decode
        full_cycle("R5 set0 default", 0, 0, 0, 1, 8, 6);
        wr_raw(BASE_IDX - 1, 8'h55);
        wr_raw(BASE_IDX + 6, 8'h55);
        full_cycle("R5 stray index", 0, 0, 0, 1, 8, 6);
        full_cycle("R5 set1 default", 1, 0, 0, 1, 1, 2);

        // R6 table across timer sets and tick settings
        for (int v = 0; v < NVEC; v++) begin
            int sel = int'(VEC[v][26]);
            int src = int'(VEC[v][25]);
            int div = int'(VEC[v][24]);
            int s = int'(VEC[v][23:16]);
            int c = int'(VEC[v][15:8]);
            int r = int'(VEC[v][7:0]);
            int p = (src != 0 ? ALT : 1) * (div != 0 ? 2 : 1);
            program_set(sel, s, c, r);
            full_cycle($sformatf("R6 vec%0d", v), sel, src, div,
                       (s + 1) * p, (c + 1) * p, (r + 2) * p);
        end

        // R8 writes during a cycle apply next cycle
        program_set(0, 2, 3, 1);
        launch(0, 0, 0);
        fork
            measure(su, cm, rc);
            begin
                repeat (2) @(negedge clk);
                program_set(0, 0, 1, 0);
            end
        join
        expect_cycle("R8 running", su, cm, rc, 3, 4, 3);
        full_cycle("R8 next", 0, 0, 0, 1, 2, 2);

        // R7 selects sampled only at acceptance
        program_set(1, 6, 6, 6);
        launch(0, 0, 0);
        fork
            measure(su, cm, rc);
            begin
                @(negedge clk);
                set_sel     = 1'b1;
                clk_div_en  = 1'b1;
                clk_src_sel = 1'b1;
            end
        join
        expect_cycle("R7 mid change", su, cm, rc, 1, 2, 2);
        set_sel = 1'b0; clk_div_en = 1'b0; clk_src_sel = 1'b0;

        // R9 start in command phase ignored
        program_set(0, 1, 7, 4);
        launch(0, 0, 0);
        fork
            measure(su, cm, rc);
            begin
                repeat (4) @(negedge clk);
                start_req = 1'b1;
                @(negedge clk);
                start_req = 1'b0;
            end
        join
        expect_cycle("R9 first", su, cm, rc, 2, 8, 6);
        repeat (3) begin
            @(negedge clk);
            chk("R9 command-phase start ignored", int'(busy), 0);
        end

        // R9 start in recovery held
        launch(0, 0, 0);
        fork
            measure(su, cm, rc);
            begin
                repeat (12) @(negedge clk);
                start_req = 1'b1;
                @(negedge clk);
                start_req = 1'b0;
            end
        join
        expect_cycle("R9 before hold", su, cm, rc, 2, 8, 6);
        @(negedge clk);
        chk("R9 held start begins", int'(busy), 1);
        measure(su, cm, rc);
        expect_cycle("R9 held cycle", su, cm, rc, 2, 8, 6);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule